// File: doc/BRIEF.md
# Synchronous Dual-Port RAM with Byte Lanes

This block is a true dual-port static memory. Each of its two ports has its own clock and reset. Each port captures its address, write data and controls on its own rising clock edge. The 18-bit word is split into two 9-bit lanes: the upper lane is bits 17..9 and the lower lane is bits 8..0. Each lane has an active-low select, so a port can read or write either half of a word, both halves, or neither. Either port can reach any location at any time. A word written through one port can be read through the other.

Each port has two chip selects, one active-low and one active-high, so that several devices can be banked without glue logic. A static mode pin on each port picks flow-through reads or pipelined reads, which add one cycle. A port never drives a tri-state pad. Instead it returns the read word together with a per-lane drive flag, and an undriven lane reads as zero. The output enable acts on those flags without passing through a clock. The array depth is set by the address-width parameter, and 13 address bits give the full 8K words. The contents of a location are not defined until that location is first written.

Top module: `dual_lane_ram`

## Requirements
- R1: A port is selected only while its `ce0_n` is 0 and its `ce1` is 1. On an edge where the port is not selected, nothing is written, and the result due from that edge leaves both drive flags at 0.
- R2: On an edge where the port is selected and `we_n` is 0, lane select bit 1 (active low) lets `wdata[17:9]` be stored and bit 0 lets `wdata[8:0]` be stored. A lane whose select bit is 1 keeps its old contents.
- R3: For a selected read (`we_n` = 1), only the lanes whose select bit is 0 have their drive flag set. A lane whose drive flag is 0 shows zero on `rdata`.
- R4: If both lane select bits are 1, a selected cycle neither writes nor drives either lane.
- R5: With `pipe` = 0, the word addressed at edge k, and its drive flags, are present on the outputs just after edge k.
- R6: With `pipe` = 1, the same result appears just after edge k+1.
- R7: With `pipe` = 1, the chip-select and read/write qualification passes through two registers. A deselect, or a write, at edge k clears the drive flags only after edge k+1, and a reselect takes just as long to show.
- R8: The lane selects pass through a single register in both modes. The lane mask sampled at edge k sets the drive flags that hold just after edge k.
- R9: `oe_n` = 1 clears both drive flags, and zeroes `rdata`, at once without a clock edge. When `oe_n` returns to 0 the flags return, again without a clock edge.
- R10: A word written through one port at edge k is returned by a read through the other port at any later edge.
- R11: The two ports may use different modes at the same time, and each port keeps its own latency.
- R12: While reset is held, and just after it is released, both drive flags are 0 and `rdata` is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| a_clk | input | 1 | Port A clock |
| a_rst_n | input | 1 | Port A asynchronous reset, active low |
| a_pipe | input | 1 | Port A read mode: 1 pipelined, 0 flow-through (static) |
| a_ce0_n | input | 1 | Port A chip select, active low |
| a_ce1 | input | 1 | Port A chip select, active high |
| a_we_n | input | 1 | Port A write strobe: 0 write, 1 read |
| a_lane_n | input | 2 | Port A lane selects, active low; bit 1 upper, bit 0 lower |
| a_addr | input | ADDR_W | Port A word address |
| a_wdata | input | 18 | Port A write data |
| a_oe_n | input | 1 | Port A output enable, active low, unclocked |
| a_rdata | output | 18 | Port A read data, zero in undriven lanes |
| a_drive | output | 2 | Port A per-lane drive flags |
| b_clk | input | 1 | Port B clock |
| b_rst_n | input | 1 | Port B asynchronous reset, active low |
| b_pipe | input | 1 | Port B read mode: 1 pipelined, 0 flow-through (static) |
| b_ce0_n | input | 1 | Port B chip select, active low |
| b_ce1 | input | 1 | Port B chip select, active high |
| b_we_n | input | 1 | Port B write strobe: 0 write, 1 read |
| b_lane_n | input | 2 | Port B lane selects, active low; bit 1 upper, bit 0 lower |
| b_addr | input | ADDR_W | Port B word address |
| b_wdata | input | 18 | Port B write data |
| b_oe_n | input | 1 | Port B output enable, active low, unclocked |
| b_rdata | output | 18 | Port B read data, zero in undriven lanes |
| b_drive | output | 2 | Port B per-lane drive flags |

## Verification
The results are due at different times. Writes land on the edge that samples them. A flow-through read, and the lane mask of any read, appear just after that same edge. A pipelined read's data and its select qualification appear one edge later. `oe_n` acts without waiting for an edge. The reference model applies each edge's inputs as that edge is reached, with reads taken before writes, and holds two stages per port. The outputs are compared at every falling clock edge. For the output enable, an extra comparison is made a moment after `oe_n` changes, in the middle of a cycle, with no clock edge in between.

// File: rtl/dual_lane_ram_pkg.sv
package dual_lane_ram_pkg;
    localparam int LANE_W    = 9;
    localparam int NUM_LANES = 2;
    localparam int WORD_W    = LANE_W * NUM_LANES;
    localparam int NUM_PORTS = 2;

    typedef logic [WORD_W-1:0]    word_t;
    typedef logic [NUM_LANES-1:0] lanes_t;

    // Per-port read-side pipeline state.
    typedef struct packed {
        logic   rd_ft;    // read qualification, first stage
        logic   rd_pl;    // read qualification, second stage
        lanes_t lane_n;   // lane mask, single stage in both modes
        word_t  data_ft;  // array word, first stage
        word_t  data_pl;  // array word, second stage
    } port_state_t;
endpackage

// File: rtl/dual_lane_ram_bank.sv
// One storage bank, written from one clock, readable at every port address.
module dual_lane_ram_bank
    import dual_lane_ram_pkg::*;
#(
    parameter int ADDR_W = 10
)(
    input  logic              clk,
    input  lanes_t            wr_lanes,
    input  logic [ADDR_W-1:0] waddr,
    input  word_t             wdata,
    input  logic [ADDR_W-1:0] raddr [NUM_PORTS],
    output word_t             rdata [NUM_PORTS]
);
    localparam int DEPTH = 1 << ADDR_W;

    logic [LANE_W-1:0] lane_rd [NUM_LANES][NUM_PORTS];

    for (genvar l = 0; l < NUM_LANES; l++) begin : g_lane
        logic [LANE_W-1:0] cells [DEPTH];

        always_ff @(posedge clk) begin
            if (wr_lanes[l]) begin
                cells[waddr] <= wdata[l*LANE_W +: LANE_W];
            end
        end

        for (genvar r = 0; r < NUM_PORTS; r++) begin : g_rd
            assign lane_rd[l][r] = cells[raddr[r]];
        end
    end

    always_comb begin
        for (int r = 0; r < NUM_PORTS; r++) begin
            for (int l = 0; l < NUM_LANES; l++) begin
                rdata[r][l*LANE_W +: LANE_W] = lane_rd[l][r];
            end
        end
    end
endmodule

// File: rtl/dual_lane_ram_core.sv
// Two-clock array: each port owns one bank and stores its data folded with
// the other bank, so the XOR of both banks is the current word.
module dual_lane_ram_core
    import dual_lane_ram_pkg::*;
#(
    parameter int ADDR_W = 10
)(
    input  logic [NUM_PORTS-1:0] clk,
    input  lanes_t               wr_lanes [NUM_PORTS],
    input  logic [ADDR_W-1:0]    addr     [NUM_PORTS],
    input  word_t                wdata    [NUM_PORTS],
    output word_t                rword    [NUM_PORTS]
);
    // bank_rd[bank][port]: bank contents at that port's address
    word_t bank_rd [NUM_PORTS][NUM_PORTS];

    for (genvar b = 0; b < NUM_PORTS; b++) begin : g_bank
        localparam int OTHER = NUM_PORTS - 1 - b;
        word_t folded;

        assign folded   = wdata[b] ^ bank_rd[OTHER][b];
        assign rword[b] = bank_rd[b][b] ^ bank_rd[OTHER][b];

        dual_lane_ram_bank #(.ADDR_W(ADDR_W)) u_bank (
            .clk      (clk[b]),
            .wr_lanes (wr_lanes[b]),
            .waddr    (addr[b]),
            .wdata    (folded),
            .raddr    (addr),
            .rdata    (bank_rd[b])
        );
    end
endmodule

// File: rtl/dual_lane_ram_port.sv
// Per-port control: selection decode, write lane enables, read pipeline and
// output gating.
module dual_lane_ram_port
    import dual_lane_ram_pkg::*;
(
    input  logic   clk,
    input  logic   rst_n,
    input  logic   pipe,
    input  logic   ce0_n,
    input  logic   ce1,
    input  logic   we_n,
    input  lanes_t lane_n,
    input  logic   oe_n,
    input  word_t  core_rword,
    output lanes_t core_wr_lanes,
    output word_t  rdata,
    output lanes_t drive
);
    port_state_t st_d, st_q;
    logic        selected;
    logic        rd_live;
    word_t       out_word;

    always_comb begin
        selected      = !ce0_n && ce1;
        core_wr_lanes = (selected && !we_n) ? ~lane_n : '0;

        st_d          = st_q;
        st_d.rd_ft    = selected && we_n;
        st_d.data_ft  = core_rword;
        st_d.rd_pl    = st_q.rd_ft;
        st_d.data_pl  = st_q.data_ft;
        st_d.lane_n   = lane_n;

        rd_live  = pipe ? st_q.rd_pl   : st_q.rd_ft;
        out_word = pipe ? st_q.data_pl : st_q.data_ft;

        for (int l = 0; l < NUM_LANES; l++) begin
            drive[l] = !oe_n && rd_live && !st_q.lane_n[l];
            rdata[l*LANE_W +: LANE_W] = drive[l] ? out_word[l*LANE_W +: LANE_W] : '0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end
endmodule

// File: rtl/dual_lane_ram.sv
module dual_lane_ram
    import dual_lane_ram_pkg::*;
#(
    parameter int ADDR_W = 10
)(
    input  logic              a_clk,
    input  logic              a_rst_n,
    input  logic              a_pipe,
    input  logic              a_ce0_n,
    input  logic              a_ce1,
    input  logic              a_we_n,
    input  logic [1:0]        a_lane_n,
    input  logic [ADDR_W-1:0] a_addr,
    input  logic [17:0]       a_wdata,
    input  logic              a_oe_n,
    output logic [17:0]       a_rdata,
    output logic [1:0]        a_drive,
    input  logic              b_clk,
    input  logic              b_rst_n,
    input  logic              b_pipe,
    input  logic              b_ce0_n,
    input  logic              b_ce1,
    input  logic              b_we_n,
    input  logic [1:0]        b_lane_n,
    input  logic [ADDR_W-1:0] b_addr,
    input  logic [17:0]       b_wdata,
    input  logic              b_oe_n,
    output logic [17:0]       b_rdata,
    output logic [1:0]        b_drive
);
    logic [NUM_PORTS-1:0] clk_v, rst_v, pipe_v, ce0_v, ce1_v, we_v, oe_v;
    lanes_t               lane_v  [NUM_PORTS];
    lanes_t               wrl_v   [NUM_PORTS];
    lanes_t               drive_v [NUM_PORTS];
    logic [ADDR_W-1:0]    addr_v  [NUM_PORTS];
    word_t                wdata_v [NUM_PORTS];
    word_t                rword_v [NUM_PORTS];
    word_t                rdata_v [NUM_PORTS];

    assign clk_v  = {b_clk,   a_clk};
    assign rst_v  = {b_rst_n, a_rst_n};
    assign pipe_v = {b_pipe,  a_pipe};
    assign ce0_v  = {b_ce0_n, a_ce0_n};
    assign ce1_v  = {b_ce1,   a_ce1};
    assign we_v   = {b_we_n,  a_we_n};
    assign oe_v   = {b_oe_n,  a_oe_n};

    assign lane_v[0]  = a_lane_n;
    assign lane_v[1]  = b_lane_n;
    assign addr_v[0]  = a_addr;
    assign addr_v[1]  = b_addr;
    assign wdata_v[0] = a_wdata;
    assign wdata_v[1] = b_wdata;

    for (genvar p = 0; p < NUM_PORTS; p++) begin : g_port
        dual_lane_ram_port u_port (
            .clk           (clk_v[p]),
            .rst_n         (rst_v[p]),
            .pipe          (pipe_v[p]),
            .ce0_n         (ce0_v[p]),
            .ce1           (ce1_v[p]),
            .we_n          (we_v[p]),
            .lane_n        (lane_v[p]),
            .oe_n          (oe_v[p]),
            .core_rword    (rword_v[p]),
            .core_wr_lanes (wrl_v[p]),
            .rdata         (rdata_v[p]),
            .drive         (drive_v[p])
        );
    end

    dual_lane_ram_core #(.ADDR_W(ADDR_W)) u_core (
        .clk      (clk_v),
        .wr_lanes (wrl_v),
        .addr     (addr_v),
        .wdata    (wdata_v),
        .rword    (rword_v)
    );

    assign a_rdata = rdata_v[0];
    assign a_drive = drive_v[0];
    assign b_rdata = rdata_v[1];
    assign b_drive = drive_v[1];
endmodule

// File: rtl/dual_lane_ram_checker.sv
module dual_lane_ram_checker
    import dual_lane_ram_pkg::*;
(
    input logic   clk,
    input logic   rst_n,
    input logic   pipe,
    input logic   ce0_n,
    input logic   ce1,
    input logic   we_n,
    input lanes_t lane_n,
    input logic   oe_n,
    input word_t  rdata,
    input lanes_t drive
);
    logic rd_req;
    assign rd_req = !ce0_n && ce1 && we_n;

    AST_OE_BLOCKS_DRIVE: assert property (@(posedge clk) disable iff (!rst_n)
        oe_n |-> (drive == '0)); // R9

    AST_FLOW_NO_READ_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (!pipe && !rd_req) |=> (drive == '0)); // R1

    AST_PIPE_NO_READ_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (pipe && !rd_req) |=> ##1 (drive == '0)); // R7

    AST_NO_LANE_NO_DRIVE: assert property (@(posedge clk) disable iff (!rst_n)
        (&lane_n) |=> (drive == '0)); // R4

    for (genvar l = 0; l < NUM_LANES; l++) begin : g_lane_chk
        AST_LANE_MASK_NEXT: assert property (@(posedge clk) disable iff (!rst_n)
            lane_n[l] |=> !drive[l]); // R8

        AST_UNDRIVEN_LANE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
            !drive[l] |-> (rdata[l*LANE_W +: LANE_W] == '0)); // R3
    end
endmodule

bind dual_lane_ram dual_lane_ram_checker chk_a (
    .clk(a_clk), .rst_n(a_rst_n), .pipe(a_pipe), .ce0_n(a_ce0_n), .ce1(a_ce1),
    .we_n(a_we_n), .lane_n(a_lane_n), .oe_n(a_oe_n), .rdata(a_rdata), .drive(a_drive)
);

bind dual_lane_ram dual_lane_ram_checker chk_b (
    .clk(b_clk), .rst_n(b_rst_n), .pipe(b_pipe), .ce0_n(b_ce0_n), .ce1(b_ce1),
    .we_n(b_we_n), .lane_n(b_lane_n), .oe_n(b_oe_n), .rdata(b_rdata), .drive(b_drive)
);

// File: tb/dual_lane_ram_test.sv
module dual_lane_ram_test;
    localparam int AW = 10;

    logic clk = 1'b0;
    always #5 clk = ~clk;

    logic          rst_n = 1'b0;
    logic          pipe  [2];
    logic          ce0_n [2];
    logic          ce1   [2];
    logic          we_n  [2];
    logic [1:0]    lane_n[2];
    logic [AW-1:0] addr  [2];
    logic [17:0]   wdata [2];
    logic          oe_n  [2];
    logic [17:0]   a_rdata, b_rdata;
    logic [1:0]    a_drive, b_drive;

    int checks = 0;
    int fails  = 0;

    // reference model
    bit [17:0] mem [1 << AW];
    bit        m_rd1 [2];
    bit        m_rd2 [2];
    bit [17:0] m_d1  [2];
    bit [17:0] m_d2  [2];
    bit [1:0]  m_lane[2];

    dual_lane_ram #(.ADDR_W(AW)) uut (
        .a_clk(clk), .a_rst_n(rst_n), .a_pipe(pipe[0]), .a_ce0_n(ce0_n[0]), .a_ce1(ce1[0]),
        .a_we_n(we_n[0]), .a_lane_n(lane_n[0]), .a_addr(addr[0]), .a_wdata(wdata[0]),
        .a_oe_n(oe_n[0]), .a_rdata(a_rdata), .a_drive(a_drive),
        .b_clk(clk), .b_rst_n(rst_n), .b_pipe(pipe[1]), .b_ce0_n(ce0_n[1]), .b_ce1(ce1[1]),
        .b_we_n(we_n[1]), .b_lane_n(lane_n[1]), .b_addr(addr[1]), .b_wdata(wdata[1]),
        .b_oe_n(oe_n[1]), .b_rdata(b_rdata), .b_drive(b_drive)
    );

    task automatic set_idle(int p);
        ce0_n[p] = 1'b1; ce1[p] = 1'b0; we_n[p] = 1'b1;
        lane_n[p] = 2'b11; oe_n[p] = 1'b0; addr[p] = '0; wdata[p] = '0;
    endtask

    task automatic set_wr(int p, int a, bit [17:0] d, bit [1:0] ln);
        ce0_n[p] = 1'b0; ce1[p] = 1'b1; we_n[p] = 1'b0;
        lane_n[p] = ln; addr[p] = AW'(a); wdata[p] = d;
    endtask

    task automatic set_rd(int p, int a, bit [1:0] ln);
        ce0_n[p] = 1'b0; ce1[p] = 1'b1; we_n[p] = 1'b1;
        lane_n[p] = ln; addr[p] = AW'(a);
    endtask

    function automatic bit [17:0] pat(int i);
        return 18'((i * 40499 + 4660) ^ (i << 11));
    endfunction

    task automatic compare(string req);
        for (int p = 0; p < 2; p++) begin
            bit        rdv;
            bit [17:0] w;
            bit [1:0]  edr;
            bit [17:0] erd;
            logic [17:0] grd;
            logic [1:0]  gdr;
            rdv = pipe[p] ? m_rd2[p] : m_rd1[p];
            w   = pipe[p] ? m_d2[p]  : m_d1[p];
            for (int l = 0; l < 2; l++) begin
                edr[l] = !oe_n[p] && rdv && !m_lane[p][l];
                erd[l*9 +: 9] = edr[l] ? w[l*9 +: 9] : 9'd0;
            end
            grd = (p == 0) ? a_rdata : b_rdata;
            gdr = (p == 0) ? a_drive : b_drive;
            checks++;
            if (grd !== erd || gdr !== edr) begin
                fails++;
                $display("FAIL %s port %0d: rdata=%h drive=%b expected rdata=%h drive=%b",
                         req, p, grd, gdr, erd, edr);
            end
        end
    endtask

    task automatic model_edge();
        bit [17:0] rw [2];
        for (int p = 0; p < 2; p++) rw[p] = mem[addr[p]];
        for (int p = 0; p < 2; p++) begin
            m_rd2[p]  = m_rd1[p];
            m_d2[p]   = m_d1[p];
            m_rd1[p]  = !ce0_n[p] && ce1[p] && we_n[p];
            m_d1[p]   = rw[p];
            m_lane[p] = lane_n[p];
        end
        for (int p = 0; p < 2; p++) begin
            if (!ce0_n[p] && ce1[p] && !we_n[p]) begin
                for (int l = 0; l < 2; l++) begin
                    if (!lane_n[p][l]) mem[addr[p]][l*9 +: 9] = wdata[p][l*9 +: 9];
                end
            end
        end
    endtask

    task automatic tick(string req);
        model_edge();
        @(posedge clk);
        @(negedge clk);
        compare(req);
    endtask

    task automatic do_reset(bit pa, bit pb);
        @(negedge clk);
        rst_n = 1'b0;
        set_idle(0); set_idle(1);
        pipe[0] = pa; pipe[1] = pb;
        repeat (2) @(negedge clk);
        for (int p = 0; p < 2; p++) begin
            m_rd1[p] = 0; m_rd2[p] = 0; m_d1[p] = '0; m_d2[p] = '0; m_lane[p] = '0;
        end
        compare("R12");
        rst_n = 1'b1;
        compare("R12");
    endtask

    task automatic flush(string req);
        set_idle(0); set_idle(1);
        tick(req); tick(req);
    endtask

    task automatic run_suite(bit pa, bit pb, string lat, string rnd);
        bit [31:0] seed;
        do_reset(pa, pb);
        // R2: fill the working range through port A
        for (int i = 0; i < 32; i++) begin
            set_wr(0, i, pat(i), 2'b00);
            tick("R2");
        end
        set_idle(0);
        for (int i = 0; i < 8; i++) begin
            set_rd(0, i, 2'b00);
            tick(lat);
        end
        flush(lat);
        // R10: port B reads what A wrote; A reads what B writes
        for (int i = 8; i < 16; i++) begin
            set_rd(1, i, 2'b00);
            tick("R10");
        end
        set_idle(1);
        set_wr(1, 40, 18'h2C3A5, 2'b00);
        tick("R10");
        set_idle(1);
        set_rd(0, 40, 2'b00);
        tick("R10");
        flush("R10");
        // R2 and R4: partial and empty lane writes
        set_wr(0, 2, 18'h2AAAA, 2'b01);
        tick("R2");
        set_wr(0, 4, 18'h15555, 2'b11);
        tick("R4");
        set_rd(0, 2, 2'b00);
        tick("R2");
        set_rd(0, 4, 2'b00);
        tick("R4");
        flush("R2");
        // R3: read lane masks
        set_rd(0, 5, 2'b10);
        tick("R3");
        set_rd(0, 5, 2'b01);
        tick("R3");
        set_rd(0, 5, 2'b11);
        tick("R4");
        flush("R3");
        // R1: writes attempted while deselected must not land
        set_wr(0, 6, 18'h3FFFF, 2'b00);
        ce0_n[0] = 1'b1;
        tick("R1");
        set_wr(0, 7, 18'h3FFFF, 2'b00);
        ce1[0] = 1'b0;
        tick("R1");
        set_rd(0, 6, 2'b00);
        tick("R1");
        set_rd(0, 7, 2'b00);
        tick("R1");
        flush("R1");
        // R7: select/deselect timing on back-to-back reads
        for (int k = 0; k < 3; k++) begin set_rd(0, 1, 2'b00); tick("R7"); end
        set_idle(0); tick("R7"); tick("R7");
        for (int k = 0; k < 3; k++) begin set_rd(0, 1, 2'b00); tick("R7"); end
        set_wr(0, 9, pat(9), 2'b00); tick("R7");
        set_rd(0, 1, 2'b00); tick("R7");
        flush("R7");
        // R8: lane mask changing every cycle
        for (int k = 0; k < 8; k++) begin
            set_rd(0, 3, 2'(k));
            tick("R8");
        end
        flush("R8");
        // R9: output enable between clock edges
        set_rd(0, 0, 2'b00);
        set_rd(1, 1, 2'b00);
        tick(lat); tick(lat);
        #1 oe_n[0] = 1'b1;
        #1 compare("R9");
        oe_n[1] = 1'b1;
        #1 compare("R9");
        oe_n[0] = 1'b0; oe_n[1] = 1'b0;
        #1 compare("R9");
        @(negedge clk);
        flush("R9");
        // both ports at once, pseudo-random
        seed = 32'h1F2E3D4C ^ {30'd0, pa, pb};
        for (int c = 0; c < 150; c++) begin
            for (int p = 0; p < 2; p++) begin
                int op;
                int a;
                seed = seed * 32'd1664525 + 32'd1013904223;
                op = int'(seed[31:30]);
                a  = int'(seed[20:16]);
                case (op)
                    0: set_idle(p);
                    1: set_wr(p, a, 18'(seed[17:0] ^ seed[29:12]), seed[9:8]);
                    2: set_rd(p, a, 2'b00);
                    default: set_rd(p, a, seed[5:4]);
                endcase
            end
            if (!we_n[0] && !we_n[1] && !ce0_n[0] && ce1[0] && !ce0_n[1] && ce1[1]
                && addr[0] == addr[1] && ((~lane_n[0] & ~lane_n[1]) != 2'b00))
                set_idle(1);
            tick(rnd);
        end
        flush(rnd);
    endtask

    initial begin
        set_idle(0); set_idle(1);
        pipe[0] = 1'b0; pipe[1] = 1'b0;
        #1 compare("R12");
        run_suite(1'b0, 1'b0, "R5", "R10");
        run_suite(1'b1, 1'b1, "R6", "R10");
        run_suite(1'b1, 1'b0, "R11", "R11");
        run_suite(1'b0, 1'b1, "R11", "R11");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog: run did not complete, actual=hung expected=done");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule